// File: doc/BRIEF.md
# Slave-Mode Word Programming Controller

This block lets an external programmer write and read back the non-volatile word array of a device over a 16-bit parallel port and three active-low strobes. The programmer first presents a command word and pulses the address strobe. The upper fifteen bits of that word give an even byte address, and bit 0 picks the operation. It then pulses the data strobe. In program mode that pulse writes the presented word into the array. In dump mode it returns the stored word on the port. A third strobe steps the address to the next word, so a run of consecutive words needs only one address phase.

Each write is a request/acknowledge exchange with an array interface, followed by one read-back cycle that compares the stored word with the word that was sent. The result of that compare drives a per-word pass flag. A sticky cumulative flag records whether every write since reset has passed. While a write is in flight, an active-low busy output is held low. An address strobe that arrives during a write is kept and takes effect when the write finishes.

Top module: `epm_slave_prog`

## Requirements
- R1: On an accepted address-strobe event the address becomes {port[15:1],0}, shown on mem_addr, and the mode becomes port bit 0 (1 = program, 0 = dump). Mode is dump and address is 0 after reset.
- R2: Each strobe passes through a two-stage synchronizer and an edge detector. A strobe that is first sampled low at clock edge k acts at edge k+2. The port is captured at that edge.
- R3: In program mode, a data-strobe event while idle raises mem_wr with mem_wdata equal to the captured word. mem_wr and mem_addr stay steady until the cycle in which mem_ack is seen, and the word is written once.
- R4: busy_n is 0 from the start of a write through its verify cycle, and 1 at all other times, including reset.
- R5: The cycle after mem_ack is a verify cycle that compares mem_rdata with the written word. word_ok takes the result at the end of that cycle. word_ok is cleared when a write starts and is 0 after reset.
- R6: word_ok holds its value until an accepted auto-increment event clears it.
- R7: An auto-increment event while idle adds 2 to the address, wrapping modulo 2^16.
- R8: all_ok is 1 after reset and goes to 0 on any failed verify. Nothing except reset sets it again.
- R9: In dump mode, a data-strobe event while idle loads the word stored at the current address onto pbus_out and raises pbus_oe. pbus_oe falls on the synchronized rising edge of the data strobe.
- R10: An address-strobe event during a write is held and applied at the end of the verify cycle. A later one during the same write replaces it.
- R11: Data-strobe and auto-increment events that arrive while busy are ignored.
- R12: A data strobe in dump mode never raises mem_wr and leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; entry into programming mode |
| addr_stb_n | input | 1 | Address/command strobe, active low |
| data_stb_n | input | 1 | Data strobe, active low |
| inc_n | input | 1 | Auto-increment strobe, active low |
| pbus_in | input | 16 | Parallel port input value |
| pbus_out | output | 16 | Dumped word |
| pbus_oe | output | 1 | Drive enable for pbus_out |
| mem_wr | output | 1 | Write request to the array |
| mem_addr | output | 16 | Array byte address (read and write) |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Array read data at mem_addr |
| mem_ack | input | 1 | Write-complete pulse |
| word_ok | output | 1 | Last written word verified |
| all_ok | output | 1 | Every write since reset verified |
| busy_n | output | 1 | Low while a write is in progress |

## Verification
The bench drives an address strobe in the middle of a write and expects the new address only after the verify cycle. A design that dropped the event would leave the old address in place. A design that applied it at once would move mem_addr during the write. The same write also sees a second data strobe and an increment pulse, and both must do nothing: otherwise a second word lands in the array or the address moves by 2. A failing location checks that all_ok stays low through a later good write, and that word_ok recovers on that write. An address at 0xFFFE followed by an increment checks the wrap to 0. The exact edge at which a strobe takes effect is probed, so an extra or missing synchronizer stage shows up.

// File: rtl/epm_pkg.sv
`timescale 1ns/1ps
package epm_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_WRITE  = 2'd1,
    SEQ_VERIFY = 2'd2
  } seq_state_e;

  // Byte address carried by a command word: bit 0 is the operation select.
  function automatic logic [WORD_W-1:0] cmd_addr(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:1], 1'b0};
  endfunction

  // Operation select: 1 = program, 0 = dump.
  function automatic logic cmd_is_prog(input logic [WORD_W-1:0] w);
    return w[0];
  endfunction

  // Sequential word step, wraps modulo 2^WORD_W.
  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a,
                                                  input int unsigned step);
    logic [WORD_W-1:0] s;
    s = WORD_W'(step);
    return a + s;
  endfunction
endpackage

// File: rtl/epm_strobe_sync.sv
`timescale 1ns/1ps
module epm_strobe_sync #(
  parameter int unsigned NUM       = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic [NUM-1:0] RISE_MASK = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] pin_n,
  output logic [NUM-1:0] edge_ev
);
  localparam int unsigned TOP = STAGES;

  for (genvar g = 0; g < NUM; g++) begin : g_ch
    logic [TOP:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[TOP-1:0], pin_n[g]};
    end
    if (RISE_MASK[g]) begin : g_rise
      assign edge_ev[g] = ~sh_q[TOP] & sh_q[TOP-1];
    end else begin : g_fall
      assign edge_ev[g] = sh_q[TOP] & ~sh_q[TOP-1];
    end
  end
endmodule

// File: rtl/epm_addr_unit.sv
`timescale 1ns/1ps
module epm_addr_unit
  import epm_pkg::*;
#(
  parameter int unsigned ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ev,
  input  logic              inc_ev,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] cmd_in,
  output logic [WORD_W-1:0] addr_q,
  output logic              prog_mode,
  output logic              inc_taken
);
  logic              pend_q;
  logic [WORD_W-1:0] pend_word_q;

  assign inc_taken = inc_ev & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      prog_mode   <= 1'b0;
      pend_q      <= 1'b0;
      pend_word_q <= '0;
    end else if (done) begin
      pend_q <= 1'b0;
      if (addr_ev) begin
        addr_q    <= cmd_addr(cmd_in);
        prog_mode <= cmd_is_prog(cmd_in);
      end else if (pend_q) begin
        addr_q    <= cmd_addr(pend_word_q);
        prog_mode <= cmd_is_prog(pend_word_q);
      end
    end else if (busy) begin
      if (addr_ev) begin
        pend_q      <= 1'b1;
        pend_word_q <= cmd_in;
      end
    end else begin
      if (addr_ev) begin
        addr_q    <= cmd_addr(cmd_in);
        prog_mode <= cmd_is_prog(cmd_in);
      end else if (inc_ev) begin
        addr_q <= step_addr(addr_q, ADDR_STEP);
      end
    end
  end
endmodule

// File: rtl/epm_write_seq.sv
`timescale 1ns/1ps
module epm_write_seq
  import epm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_ev,
  input  logic              prog_rise,
  input  logic              inc_taken,
  input  logic              prog_mode,
  input  logic [WORD_W-1:0] data_in,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              mem_wr,
  output logic [WORD_W-1:0] wdata_q,
  output logic              verify_pass,
  output logic              word_ok,
  output logic              all_ok,
  output logic              dump_oe,
  output logic [WORD_W-1:0] dump_q
);
  seq_state_e state_q;

  assign busy        = (state_q != SEQ_IDLE);
  assign done        = (state_q == SEQ_VERIFY);
  assign mem_wr      = (state_q == SEQ_WRITE);
  assign verify_pass = (mem_rdata == wdata_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      wdata_q <= '0;
      word_ok <= 1'b0;
      all_ok  <= 1'b1;
      dump_oe <= 1'b0;
      dump_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (prog_ev) begin
            if (prog_mode) begin
              state_q <= SEQ_WRITE;
              wdata_q <= data_in;
              word_ok <= 1'b0;
            end else begin
              dump_q  <= mem_rdata;
              dump_oe <= 1'b1;
            end
          end
          if (inc_taken) word_ok <= 1'b0;
        end
        SEQ_WRITE: begin
          if (mem_ack) state_q <= SEQ_VERIFY;
        end
        SEQ_VERIFY: begin
          state_q <= SEQ_IDLE;
          word_ok <= verify_pass;
          all_ok  <= all_ok & verify_pass;
        end
        default: state_q <= SEQ_IDLE;
      endcase
      if (prog_rise) dump_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/epm_slave_prog.sv
`timescale 1ns/1ps
module epm_slave_prog
  import epm_pkg::*;
#(
  parameter int unsigned ADDR_STEP   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb_n,
  input  logic              data_stb_n,
  input  logic              inc_n,
  input  logic [WORD_W-1:0] pbus_in,
  output logic [WORD_W-1:0] pbus_out,
  output logic              pbus_oe,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              word_ok,
  output logic              all_ok,
  output logic              busy_n
);
  // channel 0: address fall, 1: data fall, 2: increment fall, 3: data rise
  localparam int unsigned NCH = 4;
  localparam logic [NCH-1:0] RISE_SEL = 4'b1000;

  logic [NCH-1:0] ev;
  logic addr_ev, prog_ev, inc_ev, prog_rise;
  logic inc_taken, busy, done, prog_mode, verify_pass;

  epm_strobe_sync #(.NUM(NCH), .STAGES(SYNC_STAGES), .RISE_MASK(RISE_SEL)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   ({data_stb_n, inc_n, data_stb_n, addr_stb_n}),
    .edge_ev (ev)
  );

  assign addr_ev   = ev[0];
  assign prog_ev   = ev[1];
  assign inc_ev    = ev[2];
  assign prog_rise = ev[3];

  epm_addr_unit #(.ADDR_STEP(ADDR_STEP)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_ev   (addr_ev),
    .inc_ev    (inc_ev),
    .busy      (busy),
    .done      (done),
    .cmd_in    (pbus_in),
    .addr_q    (mem_addr),
    .prog_mode (prog_mode),
    .inc_taken (inc_taken)
  );

  epm_write_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_ev     (prog_ev),
    .prog_rise   (prog_rise),
    .inc_taken   (inc_taken),
    .prog_mode   (prog_mode),
    .data_in     (pbus_in),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .busy        (busy),
    .done        (done),
    .mem_wr      (mem_wr),
    .wdata_q     (mem_wdata),
    .verify_pass (verify_pass),
    .word_ok     (word_ok),
    .all_ok      (all_ok),
    .dump_oe     (pbus_oe),
    .dump_q      (pbus_out)
  );

  assign busy_n = ~busy;
endmodule

// File: rtl/epm_slave_prog_chk.sv
`timescale 1ns/1ps
module epm_slave_prog_chk #(
  parameter int unsigned ADDR_STEP = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_n,
  input logic        mem_wr,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic        word_ok,
  input logic        all_ok,
  input logic        pbus_oe,
  input logic        inc_taken
);
  localparam logic [15:0] STEP16 = 16'(ADDR_STEP);

  p_write_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr)));

  p_busy_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !busy_n);

  p_inc_clears_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_taken |=> !word_ok);

  p_inc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_taken |=> (mem_addr == 16'($past(mem_addr) + STEP16)));

  p_all_ok_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(all_ok));

  p_dump_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pbus_oe |-> !mem_wr);
endmodule

bind epm_slave_prog epm_slave_prog_chk #(.ADDR_STEP(ADDR_STEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_n    (busy_n),
  .mem_wr    (mem_wr),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .word_ok   (word_ok),
  .all_ok    (all_ok),
  .pbus_oe   (pbus_oe),
  .inc_taken (inc_taken)
);

// File: tb/tb_epm_slave_prog.sv
`timescale 1ns/1ps
module tb_epm_slave_prog;
  localparam int WLAT = 12;
  localparam logic [15:0] BAD = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_stb_n = 1'b1, data_stb_n = 1'b1, inc_n = 1'b1;
  logic [15:0] pbus_in = '0;
  logic [15:0] pbus_out, mem_addr, mem_wdata, mem_rdata;
  logic pbus_oe, mem_wr, word_ok, all_ok, busy_n;
  logic mem_ack;

  always #2.5 clk = ~clk;

  epm_slave_prog dut (
    .clk(clk), .rst_n(rst_n), .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
    .inc_n(inc_n), .pbus_in(pbus_in), .pbus_out(pbus_out), .pbus_oe(pbus_oe),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .word_ok(word_ok),
    .all_ok(all_ok), .busy_n(busy_n)
  );

  // Array stub: fixed write latency, one weak location stores a flipped bit.
  logic [15:0] tbmem [0:255];
  int wcnt;
  assign mem_rdata = tbmem[mem_addr[8:1]];
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
      for (int i = 0; i < 256; i++) tbmem[i] <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_wr && !mem_ack) begin
        if (wcnt == WLAT - 1) begin
          tbmem[mem_addr[8:1]] <= (mem_addr == BAD) ? (mem_wdata ^ 16'h0001) : mem_wdata;
          mem_ack <= 1'b1;
          wcnt    <= 0;
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  logic [2:0] ha, hp, hi;
  int m_state;
  logic [15:0] m_addr, m_pw, m_wdata, m_dout;
  logic m_prog, m_pend, m_wok, m_allok, m_oe;
  bit fa, fp, rp, fi, okv;

  task automatic load_cmd(input logic [15:0] w);
    m_addr = {w[15:1], 1'b0};
    m_prog = w[0];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ha = '1; hp = '1; hi = '1;
      m_state = 0; m_addr = '0; m_prog = 0; m_pend = 0; m_pw = '0;
      m_wdata = '0; m_wok = 0; m_allok = 1; m_oe = 0; m_dout = '0;
    end else begin
      fa = ha[2] & ~ha[1];
      fp = hp[2] & ~hp[1];
      rp = ~hp[2] & hp[1];
      fi = hi[2] & ~hi[1];
      ha = {ha[1:0], addr_stb_n};
      hp = {hp[1:0], data_stb_n};
      hi = {hi[1:0], inc_n};
      case (m_state)
        0: begin
          if (fp) begin
            if (m_prog) begin m_state = 1; m_wdata = pbus_in; m_wok = 0; end
            else begin m_dout = tbmem[m_addr[8:1]]; m_oe = 1; end
          end
          if (fi) begin m_addr = m_addr + 16'd2; m_wok = 0; end
          if (fa) load_cmd(pbus_in);
        end
        1: begin
          if (fa) begin m_pend = 1; m_pw = pbus_in; end
          if (mem_ack) m_state = 2;
        end
        default: begin
          okv = (m_addr != BAD);
          m_wok = okv;
          m_allok = m_allok & okv;
          m_state = 0;
          if (fa) load_cmd(pbus_in);
          else if (m_pend) load_cmd(m_pw);
          m_pend = 0;
        end
      endcase
      if (rp) m_oe = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_addr == m_addr, "R1 address", mem_addr, m_addr);
      chk(mem_wr == (m_state == 1), "R3 write request", mem_wr, m_state == 1);
      if (mem_wr) chk(mem_wdata == m_wdata, "R3 write data", mem_wdata, m_wdata);
      chk(busy_n == (m_state == 0), "R4 busy", busy_n, m_state == 0);
      chk(word_ok == m_wok, "R5 word verify", word_ok, m_wok);
      chk(all_ok == m_allok, "R8 cumulative", all_ok, m_allok);
      chk(pbus_oe == m_oe, "R9 drive enable", pbus_oe, m_oe);
      if (m_oe) chk(pbus_out == m_dout, "R9 dump data", pbus_out, m_dout);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_addr(input logic [15:0] w);
    @(negedge clk); pbus_in = w; addr_stb_n = 0;
    cyc(5); addr_stb_n = 1; cyc(4);
  endtask

  task automatic do_prog(input logic [15:0] w);
    @(negedge clk); pbus_in = w; data_stb_n = 0;
    cyc(6); data_stb_n = 1; cyc(WLAT + 8);
  endtask

  task automatic do_inc;
    @(negedge clk); inc_n = 0;
    cyc(4); inc_n = 1; cyc(4);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1;
    @(negedge clk);
    chk(busy_n == 1 && mem_wr == 0, "R4 reset idle", {busy_n, mem_wr}, 2'b10);
    chk(all_ok == 1 && word_ok == 0, "R8 reset flags", {all_ok, word_ok}, 2'b10);
    chk(mem_addr == 0 && pbus_oe == 0, "R1 reset address", mem_addr, 0);

    // R2: event lands on the third edge after the strobe is driven low.
    @(negedge clk); pbus_in = 16'h0011; addr_stb_n = 0;
    cyc(1); chk(mem_addr == 16'h0000, "R2 not yet (1)", mem_addr, 16'h0000);
    cyc(1); chk(mem_addr == 16'h0000, "R2 not yet (2)", mem_addr, 16'h0000);
    cyc(1); chk(mem_addr == 16'h0010, "R2 applied (3)", mem_addr, 16'h0010);
    cyc(3); addr_stb_n = 1; cyc(4);

    do_prog(16'hA5A5);
    chk(tbmem[8] == 16'hA5A5, "R3 stored word", tbmem[8], 16'hA5A5);
    chk(word_ok == 1, "R5 good word", word_ok, 1);
    cyc(10);
    chk(word_ok == 1, "R6 holds", word_ok, 1);
    do_inc();
    chk(word_ok == 0, "R6 cleared by increment", word_ok, 0);
    chk(mem_addr == 16'h0012, "R7 step", mem_addr, 16'h0012);
    do_prog(16'h1234);
    do_inc();
    do_prog(16'hBEEF);
    chk(tbmem[10] == 16'hBEEF, "R7 sequential write", tbmem[10], 16'hBEEF);

    // R10/R11: address, data and increment strobes during a write.
    do_addr(16'h0017);
    @(negedge clk); pbus_in = 16'hC0DE; data_stb_n = 0;
    cyc(4); data_stb_n = 1;
    cyc(2); pbus_in = 16'h0041; addr_stb_n = 0; inc_n = 0;
    cyc(4); addr_stb_n = 1; inc_n = 1; pbus_in = 16'hFFFF; data_stb_n = 0;
    cyc(4); data_stb_n = 1;
    cyc(WLAT + 12);
    chk(mem_addr == 16'h0040, "R10 held address applied", mem_addr, 16'h0040);
    chk(tbmem[11] == 16'hC0DE, "R11 first write kept", tbmem[11], 16'hC0DE);
    chk(tbmem[32] == 16'h0000, "R11 no second write", tbmem[32], 0);

    // R8: failing location, then a good one.
    do_prog(16'h5555);
    chk(word_ok == 0, "R5 failed verify", word_ok, 0);
    chk(all_ok == 0, "R8 cleared", all_ok, 0);
    do_addr(16'h0021);
    do_prog(16'h7777);
    chk(word_ok == 1, "R5 recovers", word_ok, 1);
    chk(all_ok == 0, "R8 stays low", all_ok, 0);

    // R9/R12: dump mode.
    do_addr(16'h0010);
    @(negedge clk); pbus_in = 16'h0000; data_stb_n = 0;
    cyc(5);
    chk(pbus_oe == 1 && pbus_out == 16'hA5A5, "R9 dump word", pbus_out, 16'hA5A5);
    chk(mem_wr == 0, "R12 no write request", mem_wr, 0);
    data_stb_n = 1; cyc(5);
    chk(pbus_oe == 0, "R9 release", pbus_oe, 0);
    chk(tbmem[8] == 16'hA5A5, "R12 array unchanged", tbmem[8], 16'hA5A5);
    do_inc();
    @(negedge clk); data_stb_n = 0; cyc(5);
    chk(pbus_out == 16'h1234, "R9 dump after step", pbus_out, 16'h1234);
    data_stb_n = 1; cyc(5);

    // R7 wrap.
    do_addr(16'hFFFF);
    chk(mem_addr == 16'hFFFE, "R1 top address", mem_addr, 16'hFFFE);
    do_inc();
    chk(mem_addr == 16'h0000, "R7 wrap", mem_addr, 0);

    cyc(5);
    summary();
    $finish;
  end
endmodule